// File: doc/BRIEF.md
# CAN Node Fault Confinement Unit

This block keeps the two error counters of a CAN node and decides which fault-confinement state the node is in: Error Active, Error Passive or Bus Off. The protocol engine around it reports single-cycle event strobes. Five strobes name the error source: CRC mismatch, stuff-rule violation, form error, own-bit monitoring mismatch and missing acknowledge. A sixth input tells whether the node was transmitting when the error was seen. Two further strobes report a frame sent or received without error. From these events the block moves the transmit error counter (TEC) and the receive error counter (REC). It then reports which kind of error flag the node may send and whether the node may drive the bus at all.

Once the node is in Bus Off it ignores all events. It watches the sampled bus level on every bit-time strobe. A run of 11 recessive samples in a row completes one idle sequence. A dominant sample starts the current run over but keeps the sequences already completed. After 128 completed sequences the node clears both counters and returns to Error Active. All inputs are plain control strobes with no flow control.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, both counters read 0, the state reads Error Active (code 2'b00), the active-flag enable is 1, the passive-flag enable is 0 and transmission is allowed.
- R2: On the clock edge after any of the five error strobes is high with `err_as_tx` = 1, and the node is not in Bus Off, TEC grows by 8. Several error strobes in the same cycle count as one error.
- R3: On the clock edge after an error strobe with `err_as_tx` = 0, outside Bus Off, REC grows by 1 and stops at 255.
- R4: A `tx_done` strobe lowers TEC by 1 and an `rx_done` strobe lowers REC by 1, neither going below 0. Both may act in the same cycle. In a cycle that carries an error strobe, both done strobes are ignored.
- R5: The state is Error Active (code 2'b00) exactly when TEC < 128 and REC < 128. In that state `active_flag_en` = 1 and `passive_flag_en` = 0.
- R6: The state is Error Passive (code 2'b01) when TEC is at most 255 and either counter is 128 or more. In that state `passive_flag_en` = 1, `active_flag_en` = 0 and `tx_enable` = 1.
- R7: When TEC would exceed 255, the state becomes Bus Off (code 2'b10) on that edge. In Bus Off `tx_enable`, `active_flag_en` and `passive_flag_en` are all 0.
- R8: In Bus Off, error strobes and done strobes have no effect, and both counters hold their values.
- R9: In Bus Off, each `bit_tick` with `bus_bit` = 1 extends the current recessive run, and a `bit_tick` with `bus_bit` = 0 restarts it. Each run of 11 completes one sequence. On the edge of the tick that completes the 128th sequence, both counters go to 0 and the state returns to Error Active.
- R10: Recessive samples taken outside Bus Off do not count toward recovery. Every entry into Bus Off starts with no run and no completed sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_crc | input | 1 | CRC error strobe |
| err_stuff | input | 1 | Stuff-rule error strobe |
| err_form | input | 1 | Form error strobe |
| err_bit | input | 1 | Own-bit monitoring error strobe |
| err_ack | input | 1 | Missing acknowledge strobe |
| err_as_tx | input | 1 | 1 when the node was transmitter for the error in this cycle |
| tx_done | input | 1 | Frame sent without error |
| rx_done | input | 1 | Frame received without error |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| bus_bit | input | 1 | Sampled bus level (0 dominant, 1 recessive) |
| tec | output | 9 | Transmit error counter |
| rec | output | 9 | Receive error counter |
| fc_state | output | 2 | 00 Error Active, 01 Error Passive, 10 Bus Off |
| active_flag_en | output | 1 | Node may send active error flags |
| passive_flag_en | output | 1 | Node may send passive error flags |
| tx_enable | output | 1 | Node may drive the bus |

## Verification
A wrong counter value shows on `tec` or `rec` on the very next edge after an event. The check runs every cycle, so a wrong step size, a missing floor or a missing ceiling is seen within one cycle of the event that exposes it. A state decision that disagrees with the thresholds shows on `fc_state` and on the three enables in the same cycle that the counter crosses 128 or 255. A recovery counter that is wrong shows only at the end of a bus-off episode: the node returns to Error Active too early or too late, at a point some 1408 recessive ticks after entry. For that reason the directed recovery case samples the state on the tick just before the expected exit and again on the exit tick itself.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;
endpackage

// File: rtl/fc_err_counter.sv
// Saturating up/down error counter with a synchronous clear and a hold.
module fc_err_counter #(
  parameter int W    = 9,
  parameter int STEP = 1,
  parameter int MAXV = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         hold,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);
  localparam logic [W:0]   STEP_X = (W+1)'(STEP);
  localparam logic [W:0]   MAX_X  = (W+1)'(MAXV);

  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, cnt} + STEP_X;
    if (clear)             cnt_nxt = '0;
    else if (hold)         cnt_nxt = cnt;
    else if (inc)          cnt_nxt = (sum > MAX_X) ? MAX_X[W-1:0] : sum[W-1:0];
    else if (dec)          cnt_nxt = (cnt == '0) ? '0 : cnt - 1'b1;
    else                   cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/fc_event_decode.sv
// Turns the protocol engine strobes into counter step commands.
module fc_event_decode #(
  parameter int N_SRC = 5
) (
  input  logic [N_SRC-1:0] err_src,
  input  logic             err_as_tx,
  input  logic             tx_done,
  input  logic             rx_done,
  output logic             tec_inc,
  output logic             rec_inc,
  output logic             tec_dec,
  output logic             rec_dec
);
  logic any_err;

  always_comb begin
    any_err = |err_src;
    tec_inc = any_err &  err_as_tx;
    rec_inc = any_err & ~err_as_tx;
    tec_dec = ~any_err & tx_done;
    rec_dec = ~any_err & rx_done;
  end
endmodule

// File: rtl/fc_busoff_recovery.sv
// Counts runs of recessive samples while the node is in bus-off.
module fc_busoff_recovery #(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bit_tick,
  input  logic bus_bit,
  output logic done
);
  localparam int RW = (RUN_LEN   > 1) ? $clog2(RUN_LEN)   : 1;
  localparam int SW = (RUN_COUNT > 1) ? $clog2(RUN_COUNT) : 1;
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
  localparam logic [SW-1:0] SEQ_LAST = SW'(RUN_COUNT - 1);

  logic [RW-1:0] run_q;
  logic [SW-1:0] seq_q;
  logic          run_end;

  always_comb begin
    run_end = active & bit_tick & bus_bit & (run_q == RUN_LAST);
    done    = run_end & (seq_q == SEQ_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      seq_q <= '0;
    end else if (!active || done) begin
      run_q <= '0;
      seq_q <= '0;
    end else if (bit_tick) begin
      if (!bus_bit) begin
        run_q <= '0;
      end else if (run_end) begin
        run_q <= '0;
        seq_q <= seq_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int CNT_W        = 9,
  parameter int PASSIVE_AT   = 128,
  parameter int BUSOFF_ABOVE = 255,
  parameter int TX_ERR_STEP  = 8,
  parameter int RX_ERR_STEP  = 1,
  parameter int REC_MAX      = 255,
  parameter int RUN_LEN      = 11,
  parameter int RUN_COUNT    = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_crc,
  input  logic             err_stuff,
  input  logic             err_form,
  input  logic             err_bit,
  input  logic             err_ack,
  input  logic             err_as_tx,
  input  logic             tx_done,
  input  logic             rx_done,
  input  logic             bit_tick,
  input  logic             bus_bit,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic [1:0]       fc_state,
  output logic             active_flag_en,
  output logic             passive_flag_en,
  output logic             tx_enable
);
  import can_fc_pkg::*;

  localparam int N_SRC = 5;
  localparam int TEC_MAX = (1 << CNT_W) - 1;
  localparam logic [CNT_W-1:0] PASS_TH = CNT_W'(PASSIVE_AT);
  localparam logic [CNT_W-1:0] OFF_TH  = CNT_W'(BUSOFF_ABOVE);

  fc_state_e state_q, state_d;
  logic      bus_off;
  logic      tec_inc, rec_inc, tec_dec, rec_dec;
  logic      rec_done;
  logic [CNT_W-1:0] tec_nxt, rec_nxt;

  assign bus_off = (state_q == FC_BUSOFF);

  fc_event_decode #(.N_SRC(N_SRC)) u_dec (
    .err_src   ({err_ack, err_bit, err_form, err_stuff, err_crc}),
    .err_as_tx (err_as_tx),
    .tx_done   (tx_done),
    .rx_done   (rx_done),
    .tec_inc   (tec_inc),
    .rec_inc   (rec_inc),
    .tec_dec   (tec_dec),
    .rec_dec   (rec_dec)
  );

  fc_err_counter #(.W(CNT_W), .STEP(TX_ERR_STEP), .MAXV(TEC_MAX)) u_tec (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (rec_done),
    .hold    (bus_off),
    .inc     (tec_inc),
    .dec     (tec_dec),
    .cnt     (tec),
    .cnt_nxt (tec_nxt)
  );

  fc_err_counter #(.W(CNT_W), .STEP(RX_ERR_STEP), .MAXV(REC_MAX)) u_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (rec_done),
    .hold    (bus_off),
    .inc     (rec_inc),
    .dec     (rec_dec),
    .cnt     (rec),
    .cnt_nxt (rec_nxt)
  );

  fc_busoff_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (bus_off),
    .bit_tick (bit_tick),
    .bus_bit  (bus_bit),
    .done     (rec_done)
  );

  always_comb begin
    if (rec_done)                                  state_d = FC_ACTIVE;
    else if (bus_off)                              state_d = FC_BUSOFF;
    else if (tec_nxt > OFF_TH)                     state_d = FC_BUSOFF;
    else if (tec_nxt >= PASS_TH || rec_nxt >= PASS_TH) state_d = FC_PASSIVE;
    else                                           state_d = FC_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FC_ACTIVE;
    else        state_q <= state_d;
  end

  assign fc_state        = state_q;
  assign active_flag_en  = (state_q == FC_ACTIVE);
  assign passive_flag_en = (state_q == FC_PASSIVE);
  assign tx_enable       = ~bus_off;
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
  parameter int CNT_W     = 9,
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_crc,
  input logic             err_stuff,
  input logic             err_form,
  input logic             err_bit,
  input logic             err_ack,
  input logic             err_as_tx,
  input logic             bit_tick,
  input logic             bus_bit,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic [1:0]       fc_state,
  input logic             tx_enable
);
  localparam int TOTAL = RUN_LEN * RUN_COUNT;
  logic any_err;
  logic [31:0] rtick;

  assign any_err = err_crc | err_stuff | err_form | err_bit | err_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rtick <= '0;
    else if (fc_state != 2'b10)          rtick <= '0;
    else if (bit_tick && bus_bit)        rtick <= rtick + 1;
  end

  assert_tx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state != 2'b10 && any_err && err_as_tx) |=> tec == $past(tec) + CNT_W'(8));

  assert_rx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state != 2'b10 && any_err && !err_as_tx && rec < CNT_W'(255))
      |=> rec == $past(rec) + CNT_W'(1));

  assert_rec_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rec <= CNT_W'(255));

  assert_active_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state == 2'b00) |-> (tec < CNT_W'(128) && rec < CNT_W'(128)));

  assert_passive_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state == 2'b01) |-> (tec <= CNT_W'(255) && (tec >= CNT_W'(128) || rec >= CNT_W'(128))));

  assert_busoff_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tec > CNT_W'(255)) |-> (fc_state == 2'b10 && !tx_enable));

  assert_busoff_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state == 2'b10 && !bit_tick) |=> ($stable(tec) && $stable(rec) && fc_state == 2'b10));

  assert_recovery_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fc_state) == 2'b10 && fc_state != 2'b10) |-> (rtick >= TOTAL && tec == '0 && rec == '0));

  assert_state_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fc_state != 2'b11);
endmodule

bind can_fault_conf can_fault_conf_chk #(
  .CNT_W(CNT_W), .RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .err_crc(err_crc), .err_stuff(err_stuff), .err_form(err_form),
  .err_bit(err_bit), .err_ack(err_ack), .err_as_tx(err_as_tx),
  .bit_tick(bit_tick), .bus_bit(bus_bit),
  .tec(tec), .rec(rec), .fc_state(fc_state), .tx_enable(tx_enable)
);

// File: tb/can_fault_conf_tb.sv
module can_fault_conf_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic [4:0] errs = '0;
  logic err_as_tx = 0, tx_done = 0, rx_done = 0, bit_tick = 0, bus_bit = 1;
  logic [8:0] tec, rec;
  logic [1:0] fc_state;
  logic active_flag_en, passive_flag_en, tx_enable;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_tec, m_rec, m_state, m_run, m_seq;

  always #5 clk = ~clk;

  can_fault_conf u_dut (
    .clk(clk), .rst_n(rst_n),
    .err_crc(errs[0]), .err_stuff(errs[1]), .err_form(errs[2]),
    .err_bit(errs[3]), .err_ack(errs[4]), .err_as_tx(err_as_tx),
    .tx_done(tx_done), .rx_done(rx_done),
    .bit_tick(bit_tick), .bus_bit(bus_bit),
    .tec(tec), .rec(rec), .fc_state(fc_state),
    .active_flag_en(active_flag_en), .passive_flag_en(passive_flag_en),
    .tx_enable(tx_enable)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int state_of(input int t, input int r);
    if (t > 255) return 2;
    if (t >= 128 || r >= 128) return 1;
    return 0;
  endfunction

  task automatic model_step(input logic [4:0] e, input logic astx, input logic tok,
                            input logic rok, input logic tk, input logic bb);
    if (m_state == 2) begin
      if (tk) begin
        if (!bb) m_run = 0;
        else begin
          m_run++;
          if (m_run == 11) begin
            m_run = 0;
            m_seq++;
            if (m_seq == 128) begin
              m_seq = 0; m_tec = 0; m_rec = 0; m_state = 0;
            end
          end
        end
      end
    end else begin
      if (|e) begin
        if (astx) m_tec += 8;
        else if (m_rec < 255) m_rec += 1;
      end else begin
        if (tok && m_tec > 0) m_tec -= 1;
        if (rok && m_rec > 0) m_rec -= 1;
      end
      m_state = state_of(m_tec, m_rec);
      m_run = 0; m_seq = 0;
    end
  endtask

  task automatic compare_all(input string tag);
    check(tec == 9'(m_tec), {tag, " tec"}, tec, m_tec);
    check(rec == 9'(m_rec), {tag, " rec"}, rec, m_rec);
    check(fc_state == 2'(m_state), {tag, " state R5/R6/R7"}, fc_state, m_state);
    check(active_flag_en == (m_state == 0), {tag, " active flag R5"}, active_flag_en, m_state == 0);
    check(passive_flag_en == (m_state == 1), {tag, " passive flag R6"}, passive_flag_en, m_state == 1);
    check(tx_enable == (m_state != 2), {tag, " tx enable R7"}, tx_enable, m_state != 2);
  endtask

  // drive inputs 2 ns after an edge, model the next edge, compare 2 ns after it
  task automatic cycle(input logic [4:0] e, input logic astx, input logic tok,
                       input logic rok, input logic tk, input logic bb);
    string tag;
    if (m_state == 2) tag = (|e || tok || rok) ? "R8" : "R9";
    else if (|e) tag = astx ? "R2" : "R3";
    else if (tok || rok) tag = "R4";
    else tag = "R10";
    errs = e; err_as_tx = astx; tx_done = tok; rx_done = rok; bit_tick = tk; bus_bit = bb;
    @(posedge clk);
    model_step(e, astx, tok, rok, tk, bb);
    #2;
    compare_all(tag);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    m_tec = 0; m_rec = 0; m_state = 0; m_run = 0; m_seq = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    compare_all("R1 reset");

    // R2: several error sources in one cycle count once
    cycle(5'b10101, 1, 0, 0, 0, 1);
    check(tec == 9'd8, "R2 multi-source once", tec, 8);
    // R4: error overrides done strobes; both done strobes in one cycle
    cycle(5'b00001, 0, 1, 1, 0, 1);
    check(tec == 9'd8 && rec == 9'd1, "R4 error beats done", tec + rec, 9);
    cycle(5'b00000, 0, 1, 1, 0, 1);
    check(tec == 9'd7 && rec == 9'd0, "R4 both decrement", tec + rec, 7);
    cycle(5'b00000, 0, 0, 1, 0, 1);
    check(rec == 9'd0, "R4 rec floor", rec, 0);

    // R3: REC up to passive then ceiling at 255
    for (int i = 0; i < 300; i++) cycle(5'b01000, 0, 0, 0, i[0], 1);
    check(rec == 9'd255, "R3 rec ceiling", rec, 255);
    check(fc_state == 2'b01, "R6 passive by rec", fc_state, 1);
    for (int i = 0; i < 255; i++) cycle(5'b00000, 0, 0, 1, 1, 1);
    check(fc_state == 2'b00, "R5 back to active", fc_state, 0);

    // R10: recessive ticks before bus-off do not count
    for (int i = 0; i < 2000; i++) cycle(5'b00000, 0, 0, 0, 1, 1);
    // drive TEC past 255
    while (m_state != 2) cycle(5'b00010, 1, 0, 0, 0, 1);
    check(tec > 9'd255 && !tx_enable, "R7 bus off entry", tec, 256);
    // R8: events ignored
    cycle(5'b11111, 1, 1, 1, 0, 1);
    cycle(5'b00100, 0, 1, 1, 0, 1);
    check(fc_state == 2'b10, "R8 still bus off", fc_state, 2);
    // R9: dominant restarts run, then 1407 recessive then final
    for (int i = 0; i < 7; i++) cycle(5'b00000, 0, 0, 0, 1, 1);
    cycle(5'b00000, 0, 0, 0, 1, 0);
    for (int i = 0; i < 1407; i++) cycle(5'b00000, 0, 0, 0, (i % 3) != 2 ? 1'b1 : 1'b1, 1);
    check(fc_state == 2'b10, "R10 no early exit", fc_state, 2);
    cycle(5'b00000, 0, 0, 0, 0, 1);
    check(fc_state == 2'b10, "R9 idle cycle no exit", fc_state, 2);
    cycle(5'b00000, 0, 0, 0, 1, 1);
    check(fc_state == 2'b00 && tec == 0 && rec == 0, "R9 recovery exit", fc_state, 0);

    // constrained random
    for (int n = 0; n < 40000; n++) begin
      logic [4:0] e;
      logic astx, tok, rok, tk, bb;
      e    = (($urandom % 16) == 0) ? 5'(1 << ($urandom % 5)) : 5'b0;
      astx = $urandom % 2;
      tok  = ($urandom % 8) == 0;
      rok  = ($urandom % 8) == 0;
      tk   = ($urandom % 2);
      bb   = ($urandom % 20) != 0;
      cycle(e, astx, tok, rok, tk, bb);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule